// File: doc/BRIEF.md
# Pair Phase Aligner

This block sets when each channel of an eight-channel sampled system opens its decimation window. The channels form four pairs. In each pair the odd channel is the reference and the even channel can be moved. A shared frame counter counts modulator-rate sample strobes. Each frame is OSR strobes long. Every channel gets a one-cycle start pulse at a set position inside the frame. The odd channel of a pair fires at the middle of the frame. The even channel fires earlier or later than that by a signed phase code, counted in modulator periods. So either channel of a pair can lead.

The phase codes come in on two 24-bit words, with two 12-bit codes in each word. The OSR comes in as a 3-bit code. The block copies the OSR and all four phase codes into shadow storage only on the last strobe of a frame. A value written in the middle of a frame therefore cannot bend a window that is already open. Phase codes whose magnitude would push the even channel to frame position 0 or beyond the frame are clamped.

Top module: `pair_phase_aligner`

## Requirements
- R1: Pair k drives channels 2k (even) and 2k+1 (odd). Pair 0 uses `phaseLo[11:0]`, pair 1 uses `phaseLo[23:12]`, pair 2 uses `phaseHi[11:0]` and pair 3 uses `phaseHi[23:12]`.
- R2: The frame length is 32 << `osrCode` strobes, so codes 0 to 7 give 32 to 4096. Strobes are numbered 0 to OSR-1 within a frame, and the count wraps after position OSR-1.
- R3: Every odd channel pulses on the clock after the strobe at frame position OSR/2.
- R4: Every even channel pulses on the clock after the strobe at frame position OSR/2 − p. Here p is its pair's code read as 12-bit two's complement, so a positive p makes the even channel lead.
- R5: A code p ≥ OSR/2 acts as OSR/2 − 1, and a code p ≤ −OSR/2 acts as −(OSR/2 − 1). No channel ever pulses at frame position 0.
- R6: `osrCode`, `phaseLo` and `phaseHi` are sampled only on the strobe at frame position OSR−1. That new setting governs the next frame. Changes made at any other time have no effect on the current frame.
- R7: After reset the frame position is 0, the OSR is 32 and all phases are zero, so all eight channels pulse together at position 16. With all phases zero, all eight pulses coincide for any OSR.
- R8: `decimStart` is all zeros during reset and in every clock cycle that does not follow a strobe. Each channel pulses exactly once per frame, for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Modulator-rate sample strobe, one clock wide |
| osrCode | input | 3 | OSR select, OSR = 32 << code |
| phaseLo | input | 24 | Phase codes of pairs 0 and 1 |
| phaseHi | input | 24 | Phase codes of pairs 2 and 3 |
| decimStart | output | 8 | Per-channel window start pulse |

## Verification
The hardest case to reach from the ports is a setting that changes in the middle of a frame. The bench must show that it lands only at the next boundary. To get there, each frame-running task writes the next frame's OSR and phases halfway through the current frame. It then checks that the current frame's pulse positions still match the old setting, and that the following frame matches the new one. The clamp limits are reached with codes at and beyond ±OSR/2, including the most negative 12-bit code. These are checked at both the smallest and the largest OSR.

// File: rtl/phase_align_pkg.sv
package phase_align_pkg;

  // Strobes from the frame control to the datapath.
  typedef struct packed {
    logic tick;       // a modulator-rate strobe arrives this cycle
    logic frameLoad;  // this strobe is the last of the frame: reload shadows
  } ctlStrobe_t;

endpackage

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl
  import phase_align_pkg::*;
#(
  parameter int OSR_CODE_W   = 3,
  parameter int OSR_MIN_LOG2 = 5,
  parameter int CNT_W        = OSR_MIN_LOG2 + (1 << OSR_CODE_W) - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleStb,
  input  logic [OSR_CODE_W-1:0] osrCode,
  output ctlStrobe_t            ctl,
  output logic [CNT_W-1:0]      framePos,
  output logic [CNT_W-1:0]      halfOsr
);

  logic [OSR_CODE_W-1:0] osrShadow;
  logic [CNT_W:0]        osrLen;
  logic [CNT_W-1:0]      lastPos;
  logic                  frameEnd;

  always_comb begin
    osrLen   = (CNT_W+1)'(1) << (32'(osrShadow) + OSR_MIN_LOG2);
    halfOsr  = osrLen[CNT_W:1];
    lastPos  = CNT_W'(osrLen - (CNT_W+1)'(1));
    frameEnd = sampleStb && (framePos == lastPos);
    ctl.tick      = sampleStb;
    ctl.frameLoad = frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framePos  <= '0;
      osrShadow <= '0;
    end else if (sampleStb) begin
      framePos <= frameEnd ? '0 : framePos + CNT_W'(1);
      if (frameEnd) osrShadow <= osrCode;
    end
  end

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    framePos <= lastPos); // R2

endmodule

// File: rtl/phase_align_datapath.sv
module phase_align_datapath
  import phase_align_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int PHASE_W   = 12,
  parameter int CNT_W     = 12,
  localparam int NUM_CH   = 2 * NUM_PAIRS,
  localparam int EW       = ((CNT_W > PHASE_W) ? CNT_W : PHASE_W) + 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     ctl,
  input  logic [CNT_W-1:0]               framePos,
  input  logic [CNT_W-1:0]               halfOsr,
  input  logic [NUM_PAIRS*PHASE_W-1:0]   phaseAll,
  output logic [NUM_CH-1:0]              decimStart
);

  logic [NUM_CH-1:0] hitNext;
  logic              oddMatch;

  assign oddMatch = ctl.tick && (framePos == halfOsr);

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic [PHASE_W-1:0] phaseShadow;
    logic signed [EW-1:0] ph, hs, lim, clamped, evenDelay;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              phaseShadow <= '0;
      else if (ctl.frameLoad) phaseShadow <= phaseAll[k*PHASE_W +: PHASE_W];
    end

    always_comb begin
      ph  = {{(EW-PHASE_W){phaseShadow[PHASE_W-1]}}, phaseShadow};
      hs  = {{(EW-CNT_W){1'b0}}, halfOsr};
      lim = hs - EW'(1);
      if (ph > lim)       clamped = lim;
      else if (ph < -lim) clamped = -lim;
      else                clamped = ph;
      evenDelay = hs - clamped;
    end

    assign hitNext[2*k]   = ctl.tick && (framePos == CNT_W'(evenDelay));
    assign hitNext[2*k+1] = oddMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decimStart <= '0;
    else       decimStart <= hitNext;
  end

  logic [NUM_PAIRS-1:0] oddBits;
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_odd
    assign oddBits[k] = decimStart[2*k+1];
  end

  AST_ODD_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (oddBits == '0) || (oddBits == '1)); // R3

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (decimStart != '0) |-> $past(ctl.tick)); // R8

  AST_NO_POS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && framePos == '0) |=> (decimStart == '0)); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      decimStart[c] |=> !decimStart[c]); // R8
  end

endmodule

// File: rtl/pair_phase_aligner.sv
module pair_phase_aligner
  import phase_align_pkg::*;
#(
  parameter int PHASE_W      = 12,
  parameter int OSR_CODE_W   = 3,
  parameter int OSR_MIN_LOG2 = 5,
  localparam int NUM_PAIRS   = 4,
  localparam int CNT_W       = OSR_MIN_LOG2 + (1 << OSR_CODE_W) - 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStb,
  input  logic [OSR_CODE_W-1:0]   osrCode,
  input  logic [2*PHASE_W-1:0]    phaseLo,
  input  logic [2*PHASE_W-1:0]    phaseHi,
  output logic [2*NUM_PAIRS-1:0]  decimStart
);

  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] framePos;
  logic [CNT_W-1:0] halfOsr;

  phase_align_ctrl #(
    .OSR_CODE_W(OSR_CODE_W), .OSR_MIN_LOG2(OSR_MIN_LOG2), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .osrCode(osrCode),
    .ctl(ctl), .framePos(framePos), .halfOsr(halfOsr)
  );

  phase_align_datapath #(
    .NUM_PAIRS(NUM_PAIRS), .PHASE_W(PHASE_W), .CNT_W(CNT_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .framePos(framePos), .halfOsr(halfOsr),
    .phaseAll({phaseHi, phaseLo}), .decimStart(decimStart)
  );

endmodule

// File: tb/test_pair_phase_aligner.sv
module test_pair_phase_aligner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [2:0]  osrCode = 3'd3;
  logic [23:0] phaseLo = 24'h123456;
  logic [23:0] phaseHi = 24'h0FF00A;
  logic [7:0]  decimStart;

  int checks = 0;
  int errors = 0;
  int hitPos[8];
  int hitCnt[8];
  int gapHits;

  always #10 clk = ~clk;

  pair_phase_aligner i_pair_phase_aligner (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .osrCode(osrCode),
    .phaseLo(phaseLo), .phaseHi(phaseHi), .decimStart(decimStart)
  );

  function automatic int expPos(int code, logic [23:0] lo, logic [23:0] hi, int ch);
    int half, lim, v;
    logic [11:0] p;
    half = (32 << code) / 2;
    if (ch % 2 == 1) return half;
    case (ch / 2)
      0: p = lo[11:0];
      1: p = lo[23:12];
      2: p = hi[11:0];
      default: p = hi[23:12];
    endcase
    v = int'(signed'(p));
    lim = half - 1;
    if (v > lim) v = lim;
    if (v < -lim) v = -lim;
    return half - v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic doStrobe(int k);
    @(negedge clk); sampleStb = 1'b1;
    @(negedge clk); sampleStb = 1'b0;
    for (int ch = 0; ch < 8; ch++)
      if (decimStart[ch]) begin hitPos[ch] = k; hitCnt[ch]++; end
    @(negedge clk);
    if (decimStart != 8'h00) gapHits++;
  endtask

  // Runs one frame of n strobes; writes the next setting halfway through.
  task automatic runFrame(int n, logic [2:0] nCode, logic [23:0] nLo, logic [23:0] nHi);
    for (int ch = 0; ch < 8; ch++) begin hitPos[ch] = -1; hitCnt[ch] = 0; end
    gapHits = 0;
    for (int k = 0; k < n; k++) begin
      if (k == n / 2) begin osrCode = nCode; phaseLo = nLo; phaseHi = nHi; end
      doStrobe(k);
    end
  endtask

  task automatic checkFrame(string req, int code, logic [23:0] lo, logic [23:0] hi);
    for (int ch = 0; ch < 8; ch++) begin
      check({req, " position"}, hitPos[ch], expPos(code, lo, hi, ch));
      check("R8 one pulse per frame", hitCnt[ch], 1);
    end
    check("R8 no pulse off strobe", gapHits, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R8 outputs during reset", int'(decimStart), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle without strobe", int'(decimStart), 0);
  endtask

  task automatic testFirstFrame();
    // Inputs held non-default since reset must not apply (R6, R7).
    runFrame(32, 3'd1, 24'hFF9005, 24'h01F000);
    checkFrame("R7 R6 reset frame", 0, 24'h0, 24'h0);
  endtask

  task automatic testPhasedFrame();
    // Pair0 +5, pair1 -7, pair2 0, pair3 +31 at OSR 64 (R1, R3, R4).
    runFrame(64, 3'd0, 24'h800064, 24'hFF0010);
    checkFrame("R1 R3 R4 R6 phased", 1, 24'hFF9005, 24'h01F000);
  endtask

  task automatic testClampSmall();
    // OSR 32: +100, -2048, +16, -16 all clamp (R5).
    runFrame(32, 3'd7, 24'h8007FF, 24'h3E8FFF);
    checkFrame("R5 R2 clamp small", 0, 24'h800064, 24'hFF0010);
  endtask

  task automatic testLargeOsr();
    // OSR 4096: +2047, -2048, -1, +1000 (R2, R5).
    runFrame(4096, 3'd2, 24'h0, 24'h0);
    checkFrame("R2 R5 large", 7, 24'h8007FF, 24'h3E8FFF);
  endtask

  task automatic testZeroPhase();
    runFrame(128, 3'd2, 24'h0, 24'h0);
    checkFrame("R7 zero phase", 2, 24'h0, 24'h0);
    for (int ch = 1; ch < 8; ch++) check("R7 all aligned", hitPos[ch], hitPos[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testFirstFrame();
    testPhasedFrame();
    testClampSmall();
    testLargeOsr();
    testZeroPhase();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule